// File: doc/BRIEF.md
# Serial Command Decoder for a Compute Unit

This block turns a stream of single bytes from a serial receiver into operations on a small compute unit, and sends a byte back through a serial transmitter when the host asks for a value. Each command opens with one header byte that holds an operation code and a 4-bit word address. A header for a write is followed by one payload byte. The other three operations use the header alone.

Once a command is complete, the decoder raises a one-cycle request to the compute unit. It then waits until the unit reports completion. A read also returns the unit's output byte to the host. The reply byte stays on the transmit port until the transmitter accepts it. While a command is in progress the decoder takes no new bytes. Any byte that arrives in that time is discarded and sets a sticky overrun flag.

Top module: `cmd_stream_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `tx_valid`, `cu_req` and `overrun` are 0.
- R2: The header byte is decoded as follows. Bits 7:6 are the operation code, with 00 = clear, 01 = write, 10 = compute and 11 = read. Bits 5:2 are the address, and bits 1:0 have no effect. The request carries these fields on `cu_op` and `cu_addr`.
- R3: A write header raises no request. The next received byte becomes `cu_wdata`, and the request is raised in the cycle after that byte is sampled.
- R4: A clear or compute header raises its request in the cycle after the header is sampled, with no further bytes needed. Once `cu_done` arrives, the next byte is again decoded as a header.
- R5: `cu_req` is high for exactly one cycle per command.
- R6: For a read, `cu_rdata` is captured in the cycle `cu_done` is high. It appears on `tx_data` with `tx_valid` high in the following cycle.
- R7: The reply stays valid and unchanged until `tx_ready` is sampled high, and `tx_valid` drops in the next cycle.
- R8: A byte that arrives between the request and the end of its command is dropped and sets `overrun`. `overrun` remains set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte offered |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the reply |
| cu_req | output | 1 | One-cycle operation request |
| cu_op | output | 2 | Operation code of the request |
| cu_addr | output | 4 | Word address of the request |
| cu_wdata | output | 8 | Payload for a write |
| cu_done | input | 1 | Compute unit finished the request |
| cu_rdata | input | 8 | Word read by the compute unit |
| overrun | output | 1 | Sticky flag for dropped bytes |

## Verification
The hardest case to create from the ports is a byte that lands in the busy window. Two moments matter: while the compute unit is still working, and while a reply waits on a stalled transmitter. To reach them, the bench's compute-unit model stretches its latency to several cycles, and `tx_ready` is held low. A stray byte is injected in each window. The bench then checks three things: no extra request appears, the reply still carries the earlier value, and the overrun flag stays set through later commands.

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  output logic          cu_req,
  output logic [1:0]    cu_op,
  output logic [AW-1:0] cu_addr,
  output logic [DW-1:0] cu_wdata,
  input  logic          cu_done,
  input  logic [DW-1:0] cu_rdata,
  output logic          overrun
);
  localparam int OPL = DW - 2;
  localparam int ADL = OPL - AW;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b11;

  typedef enum logic [2:0] {S_CMD, S_DATA, S_ISSUE, S_BUSY, S_REPLY} state_t;
  state_t state;

  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, reply_q;
  logic          ovr_q;

  wire idle_rx = (state == S_CMD) || (state == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_CMD;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      reply_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (rx_valid && !idle_rx) ovr_q <= 1'b1;
      case (state)
        S_CMD: if (rx_valid) begin
          op_q   <= rx_data[DW-1:OPL];
          addr_q <= rx_data[OPL-1:ADL];
          state  <= (rx_data[DW-1:OPL] == OP_WRITE) ? S_DATA : S_ISSUE;
        end
        S_DATA: if (rx_valid) begin
          wdata_q <= rx_data;
          state   <= S_ISSUE;
        end
        S_ISSUE: state <= S_BUSY;
        S_BUSY: if (cu_done) begin
          if (op_q == OP_READ) begin
            reply_q <= cu_rdata;
            state   <= S_REPLY;
          end else begin
            state <= S_CMD;
          end
        end
        S_REPLY: if (tx_ready) state <= S_CMD;
        default: state <= S_CMD;
      endcase
    end
  end

  assign cu_req   = (state == S_ISSUE);
  assign cu_op    = op_q;
  assign cu_addr  = addr_q;
  assign cu_wdata = wdata_q;
  assign tx_valid = (state == S_REPLY);
  assign tx_data  = reply_q;
  assign overrun  = ovr_q;

  a_r5_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cu_req |=> !cu_req);

  a_r4_req_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    cu_req |-> $past(rx_valid));

  a_r6_reply_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(cu_done));

  a_r7_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r7_reply_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!tx_valid && !cu_req && !overrun));
endmodule

// File: tb/tb_cmd_stream_decoder.sv
module tb_cmd_stream_decoder;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 0;
  logic       cu_req;
  logic [1:0] cu_op;
  logic [3:0] cu_addr;
  logic [7:0] cu_wdata;
  logic       cu_done = 0;
  logic [7:0] cu_rdata = 0;
  logic       overrun;

  int total = 0;
  int bad = 0;
  int req_count = 0;
  int cu_delay = 3;
  logic [3:0] cu_cnt = 0;
  logic [1:0] p_op;
  logic [3:0] p_addr;
  logic [7:0] p_wdata;
  logic [7:0] mem [16];

  always #5 clk = ~clk;

  cmd_stream_decoder dut (.*);

  always @(posedge clk) begin
    cu_done <= 1'b0;
    if (cu_req) begin
      req_count <= req_count + 1;
      p_op <= cu_op; p_addr <= cu_addr; p_wdata <= cu_wdata;
      cu_cnt <= cu_delay[3:0];
    end else if (cu_cnt != 0) begin
      cu_cnt <= cu_cnt - 1;
      if (cu_cnt == 1) begin
        cu_done <= 1'b1;
        cu_rdata <= mem[p_addr];
        case (p_op)
          2'b00: for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
          2'b01: mem[p_addr] <= p_wdata;
          2'b10: mem[15] <= mem[0] + mem[1];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic settle();
    repeat (cu_delay + 4) @(negedge clk);
  endtask

  task automatic write_word(logic [3:0] a, logic [7:0] d);
    send_byte({2'b01, a, 2'b10});
    send_byte(d);
    settle();
  endtask

  task automatic read_word(logic [3:0] a, logic [7:0] exp, string req);
    int n = 0;
    send_byte({2'b11, a, 2'b01});
    while (!tx_valid && n < 40) begin @(negedge clk); n++; end
    check(req, tx_valid, 1);
    check(req, tx_data, exp);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    check("R7 drop", tx_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 tx_valid", tx_valid, 0);
    check("R1 cu_req", cu_req, 0);
    check("R1 overrun", overrun, 0);
  endtask

  task automatic t_write();
    int c0 = req_count;
    send_byte(8'h57);
    check("R3 no req after header", cu_req, 0);
    repeat (4) @(negedge clk);
    check("R3 waits for payload", req_count, c0);
    send_byte(8'hA5);
    check("R3 req after payload", cu_req, 1);
    check("R2 op", cu_op, 1);
    check("R2 addr", cu_addr, 5);
    check("R3 wdata", cu_wdata, 8'hA5);
    @(negedge clk);
    check("R5 single pulse", cu_req, 0);
    settle();
    check("R5 one request", req_count, c0 + 1);
  endtask

  task automatic t_read();
    int n = 0;
    send_byte(8'hD4);
    check("R2 read op", cu_op, 3);
    while (!tx_valid && n < 40) begin @(negedge clk); n++; end
    check("R6 reply valid", tx_valid, 1);
    check("R6 reply data", tx_data, 8'hA5);
    repeat (4) begin
      @(negedge clk);
      check("R7 hold valid", tx_valid, 1);
      check("R7 hold data", tx_data, 8'hA5);
    end
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    check("R7 released", tx_valid, 0);
  endtask

  task automatic t_overrun();
    int c0 = req_count;
    int n = 0;
    cu_delay = 8;
    send_byte(8'hD6);
    send_byte(8'h57);
    check("R8 overrun set", overrun, 1);
    while (!tx_valid && n < 40) begin @(negedge clk); n++; end
    send_byte(8'h80);
    check("R8 reply kept", tx_data, 8'hA5);
    check("R8 no extra req", req_count, c0 + 1);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    cu_delay = 3;
    write_word(4'd7, 8'h11);
    check("R8 sticky", overrun, 1);
  endtask

  task automatic t_compute();
    int c0;
    write_word(4'd0, 8'h21);
    write_word(4'd1, 8'h13);
    c0 = req_count;
    send_byte(8'h83);
    check("R4 compute req", cu_req, 1);
    check("R4 compute op", cu_op, 2);
    settle();
    check("R4 one compute req", req_count, c0 + 1);
    read_word(4'd15, 8'h34, "R4 compute result");
  endtask

  task automatic t_clear();
    send_byte(8'h3F);
    check("R4 clear req", cu_req, 1);
    check("R2 clear op", cu_op, 0);
    check("R2 clear addr", cu_addr, 15);
    settle();
    read_word(4'd5, 8'h00, "R4 cleared");
  endtask

  task automatic t_rereset();
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 in reset overrun", overrun, 0);
    check("R1 in reset req", cu_req, 0);
    rst_n = 1;
    @(negedge clk);
    check("R8 cleared by reset", overrun, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_overrun();
    t_compute();
    t_clear();
    t_rereset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule